// File: doc/BRIEF.md
# Masked Time-Date Alarm and Interrupt Combiner

This block watches the running clock-calendar and raises an alarm when the programmed alarm fields match it. The clock-calendar is supplied as two packed BCD words: a time word and a date word. The alarm is held in two registers that use the same field layout as those words. Each field has its own enable bit, and a field whose enable bit is clear takes no part in the comparison. There is no year field in the alarm. The alarm flag is one of five status bits. The other four are set by single-cycle event pulses that come from the counter logic.

Software programs the alarm through a simple word-addressed write/read port. The same port gives access to the status, write-one-to-clear status, write-one-to-set enable, write-one-to-clear enable and mask readback registers. The mask can only be changed through the set and clear registers. The single level interrupt output is high while any status bit is set and enabled.

Register map (word address on `reg_addr`): 0 time alarm, 1 date alarm, 2 status (read), 3 status clear, 4 enable set, 5 enable clear, 6 mask (read). Any other address reads zero.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: Reset (synchronous, active low) clears both alarm registers, all five status bits and all five mask bits, and `irq` is low afterwards.
- R2: The time alarm register (address 0) keeps only seconds [6:0] + enable bit 7, minutes [14:8] + enable bit 15, and hours [21:16] + enable bit 23. All other bits read as 0, so a write of all ones reads back 0x00BFFFFF.
- R3: The date alarm register (address 1) keeps only month [20:16] + enable bit 23 and day of month [29:24] + enable bit 31. A write of all ones reads back 0xBF9F0000.
- R4: The alarm matches when every enabled field equals the field at the same bit position of `cur_time` (seconds, minutes, hours) or `cur_date` (month, day). A field whose enable bit is clear is ignored.
- R5: If no alarm field is enabled, the alarm status bit never sets.
- R6: Alarm status (bit 1) sets on a `sec_tick` cycle where the alarm matches but did not match at the previous `sec_tick`. It does not set again on later ticks while the match holds.
- R7: Status bits are: bit 0 update acknowledge (`ev_upd_ack`), bit 1 alarm, bit 2 second event (`sec_tick`), bit 3 time event (`ev_time`), bit 4 date event (`ev_date`). Each source sets its bit on the clock edge where it is high, and the status reads at address 2.
- R8: A write to address 3 clears each status bit written as 1 and leaves the other bits unchanged.
- R9: If a source sets a status bit in the same cycle as a clear write to that bit, the bit ends up set.
- R10: A write to address 4 sets each mask bit written as 1, and a write to address 5 clears each mask bit written as 1. The mask appears on `irq_mask` and reads at address 6.
- R11: `irq` is high exactly when some status bit and the same mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_time | input | 32 | Running time word, packed BCD (seconds, minutes, hours) |
| cur_date | input | 32 | Running date word, packed BCD (month, day of month) |
| sec_tick | input | 1 | One-cycle pulse once per second |
| ev_upd_ack | input | 1 | Update-acknowledge event pulse |
| ev_time | input | 1 | Time event pulse |
| ev_date | input | 1 | Date event pulse |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| alarm_flag | output | 1 | Alarm status bit |
| irq_mask | output | 5 | Current interrupt mask |
| irq | output | 1 | Level interrupt |

## Verification
Every register write and every event pulse takes effect on the clock edge where it is sampled. Status, mask, `alarm_flag` and `irq` are therefore due one cycle after the stimulus, and `reg_rdata` follows `reg_addr` in the same cycle. The bench changes inputs one time unit after a rising edge and samples one time unit after the next rising edge, so each result is read in the cycle it is due. The alarm check sweeps every combination of field enables against every combination of differing fields. Before each case the bench applies a tick with no match, so the first-match rule starts from a known state.

// File: rtl/alarm_irq_pkg.sv
// Shared constants for the alarm and interrupt combiner.
// Holds the register addresses, the status bit indices and the alarm field geometry.
package alarm_irq_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 3;
    localparam int NUM_SRC    = 5;
    localparam int NUM_FIELDS = 5;

    localparam logic [ADDR_W-1:0] A_TIME_ALM = 3'd0;
    localparam logic [ADDR_W-1:0] A_DATE_ALM = 3'd1;
    localparam logic [ADDR_W-1:0] A_STATUS   = 3'd2;
    localparam logic [ADDR_W-1:0] A_ST_CLR   = 3'd3;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 3'd4;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 3'd5;
    localparam logic [ADDR_W-1:0] A_MASK     = 3'd6;

    localparam int SRC_UPD  = 0;
    localparam int SRC_ALM  = 1;
    localparam int SRC_SEC  = 2;
    localparam int SRC_TIME = 3;
    localparam int SRC_DATE = 4;

    // Field geometry: 0 sec, 1 min, 2 hour (time word), 3 month, 4 day (date word)
    function automatic int fld_lo(input int i);
        case (i)
            0: return 0;   1: return 8;   2: return 16;
            3: return 16;  default: return 24;
        endcase
    endfunction

    function automatic int fld_w(input int i);
        case (i)
            0: return 7;   1: return 7;   2: return 6;
            3: return 5;   default: return 6;
        endcase
    endfunction

    function automatic int fld_en(input int i);
        case (i)
            0: return 7;   1: return 15;  2: return 23;
            3: return 23;  default: return 31;
        endcase
    endfunction

    function automatic bit fld_in_date(input int i);
        return (i >= 3);
    endfunction

    // Bits kept by each alarm register
    localparam logic [DATA_W-1:0] TIME_ALM_KEEP = 32'h00BF_FFFF;
    localparam logic [DATA_W-1:0] DATE_ALM_KEEP = 32'hBF9F_0000;
endpackage

// File: rtl/alarm_match.sv
// Compares the alarm fields against the current time and date words.
// Assumes both sides use the same packed field layout. A field whose enable bit
// is clear always counts as equal. any_en tells whether at least one field is enabled.
module alarm_match
    import alarm_irq_pkg::*;
#(
    parameter int NF = NUM_FIELDS
) (
    input  logic [DATA_W-1:0] alm_time,
    input  logic [DATA_W-1:0] alm_date,
    input  logic [DATA_W-1:0] cur_time,
    input  logic [DATA_W-1:0] cur_date,
    output logic              match,
    output logic              any_en
);
    logic [NF-1:0] fld_ok;
    logic [NF-1:0] fld_on;

    for (genvar i = 0; i < NF; i++) begin : g_fld
        localparam int LO = fld_lo(i);
        localparam int W  = fld_w(i);
        localparam int EN = fld_en(i);
        logic [DATA_W-1:0] a_word;
        logic [DATA_W-1:0] c_word;
        // Select which word pair this field lives in
        assign a_word    = fld_in_date(i) ? alm_date : alm_time;
        assign c_word    = fld_in_date(i) ? cur_date : cur_time;
        assign fld_on[i] = a_word[EN];
        assign fld_ok[i] = !a_word[EN] || (a_word[LO +: W] == c_word[LO +: W]);
    end

    // Overall match needs every field to pass and at least one to be enabled
    always_comb begin
        any_en = |fld_on;
        match  = any_en && (&fld_ok);
    end
endmodule

// File: rtl/alarm_trigger.sv
// Turns the level match into a one-shot hit on the second tick.
// Assumes sec_tick is a one-cycle pulse. The match is sampled only on ticks,
// so a hit needs a tick with a match that the previous tick did not see.
module alarm_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic match,
    input  logic any_en,
    output logic hit
);
    logic seen_q;

    // Remember the match result seen at the last tick
    always_ff @(posedge clk) begin
        if (!rst_n)        seen_q <= 1'b0;
        else if (sec_tick) seen_q <= match;
    end

    // A hit is a rising match observed on a tick
    always_comb hit = sec_tick && match && !seen_q;

    p_hit_needs_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (match && sec_tick));
    p_no_enable_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |-> !hit);
    p_single_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/irq_status.sv
// Status register with one set input per source and a write-one-to-clear vector.
// When a set and a clear hit the same bit in one cycle, the set wins.
module irq_status
    import alarm_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] status
);
    logic [N-1:0] st_q;

    // Clear the written ones first, then apply the new events
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_vec) | set_vec;
    end

    assign status = st_q;

    p_set_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & $past(set_vec)) == $past(set_vec)));
    p_unclr_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & $past(st_q & ~clr_vec)) == $past(st_q & ~clr_vec)));
endmodule

// File: rtl/irq_mask.sv
// Interrupt mask that changes only through set and clear strobes.
// If both strobes name the same bit in one cycle, the set wins.
module irq_mask
    import alarm_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] mask
);
    logic [N-1:0] m_q;

    // Apply the clear strobe, then the set strobe
    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= (m_q & ~clr_vec) | set_vec;
    end

    assign mask = m_q;

    p_mask_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((m_q & $past(set_vec)) == $past(set_vec)));
    p_mask_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((m_q & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/alarm_irq_ctrl.sv
// Top of the alarm and interrupt combiner. It holds the alarm registers, decodes
// the register port, gathers the event sources into status and drives the level
// interrupt. Assumes the event inputs and sec_tick are single-cycle pulses and
// that cur_time and cur_date are stable around the tick.
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cur_time,
    input  logic [DATA_W-1:0] cur_date,
    input  logic              sec_tick,
    input  logic              ev_upd_ack,
    input  logic              ev_time,
    input  logic              ev_date,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              alarm_flag,
    output logic [NUM_SRC-1:0] irq_mask,
    output logic              irq
);
    logic [DATA_W-1:0]  alm_time_q, alm_date_q;
    logic               match, any_en, hit;
    logic [NUM_SRC-1:0] st_set, st_clr, en_set, en_clr, status, mask;

    // Hold the alarm registers, keeping only the defined bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_time_q <= '0;
            alm_date_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_TIME_ALM) alm_time_q <= reg_wdata & TIME_ALM_KEEP;
            if (reg_addr == A_DATE_ALM) alm_date_q <= reg_wdata & DATE_ALM_KEEP;
        end
    end

    alarm_match u_match (
        .alm_time (alm_time_q),
        .alm_date (alm_date_q),
        .cur_time (cur_time),
        .cur_date (cur_date),
        .match    (match),
        .any_en   (any_en)
    );

    alarm_trigger u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .match    (match),
        .any_en   (any_en),
        .hit      (hit)
    );

    // Gather the sources and decode the write-one strobes
    always_comb begin
        st_set           = '0;
        st_set[SRC_UPD]  = ev_upd_ack;
        st_set[SRC_ALM]  = hit;
        st_set[SRC_SEC]  = sec_tick;
        st_set[SRC_TIME] = ev_time;
        st_set[SRC_DATE] = ev_date;
        st_clr = (reg_wr && reg_addr == A_ST_CLR) ? reg_wdata[NUM_SRC-1:0] : '0;
        en_set = (reg_wr && reg_addr == A_EN_SET) ? reg_wdata[NUM_SRC-1:0] : '0;
        en_clr = (reg_wr && reg_addr == A_EN_CLR) ? reg_wdata[NUM_SRC-1:0] : '0;
    end

    irq_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (st_set),
        .clr_vec (st_clr),
        .status  (status)
    );

    irq_mask u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (en_set),
        .clr_vec (en_clr),
        .mask    (mask)
    );

    // Read mux over the word addresses
    always_comb begin
        case (reg_addr)
            A_TIME_ALM: reg_rdata = alm_time_q;
            A_DATE_ALM: reg_rdata = alm_date_q;
            A_STATUS:   reg_rdata = {{(DATA_W-NUM_SRC){1'b0}}, status};
            A_MASK:     reg_rdata = {{(DATA_W-NUM_SRC){1'b0}}, mask};
            default:    reg_rdata = '0;
        endcase
    end

    // Drive the flag, the mask view and the level interrupt
    always_comb begin
        alarm_flag = status[SRC_ALM];
        irq_mask   = mask;
        irq        = |(status & mask);
    end

    p_time_alm_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_time_q & ~TIME_ALM_KEEP) == '0);
    p_date_alm_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_date_q & ~DATE_ALM_KEEP) == '0);
    p_hit_raises_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> alarm_flag);
    p_irq_needs_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq);
endmodule

// File: tb/tb_alarm_irq_ctrl.sv
module tb_alarm_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cur_time, cur_date, reg_wdata, reg_rdata;
    logic        sec_tick, ev_upd_ack, ev_time, ev_date, reg_wr;
    logic [2:0]  reg_addr;
    logic        alarm_flag, irq;
    logic [4:0]  irq_mask;
    int checks = 0, fails = 0, cycles = 0;

    always #10 clk = ~clk;

    alarm_irq_ctrl dut (.*);

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic tick();
        sec_tick = 1'b1; step(); sec_tick = 1'b0;
    endtask

    function automatic logic [31:0] ptime(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h);
        return {8'h00, 2'b00, h, 1'b0, m, 1'b0, s};
    endfunction

    function automatic logic [31:0] pdate(input logic [4:0] mo, input logic [5:0] d);
        return {2'b00, d, 3'b000, mo, 16'h0000};
    endfunction

    // Alarm values; the differing value flips bit 0 of the field
    localparam logic [6:0] AS = 7'h45, AM = 7'h30;
    localparam logic [5:0] AH = 6'h12, AD = 6'h19;
    localparam logic [4:0] AMO = 5'h07;

    task automatic set_cur(input logic [4:0] diff);
        cur_time = ptime(AS ^ {6'b0, diff[0]}, AM ^ {6'b0, diff[1]}, AH ^ {5'b0, diff[2]});
        cur_date = pdate(AMO ^ {4'b0, diff[3]}, AD ^ {5'b0, diff[4]});
    endtask

    task automatic program_alarm(input logic [4:0] en);
        wr(3'd0, ptime(AS, AM, AH) | {8'h0, en[2], 7'h0, en[1], 7'h0, en[0], 7'h0});
        wr(3'd1, pdate(AMO, AD) | {en[4], 7'h0, en[3], 23'h0});
    endtask

    initial begin
        logic [31:0] v;
        logic [4:0]  model;
        rst_n = 1'b0; sec_tick = 0; ev_upd_ack = 0; ev_time = 0; ev_date = 0;
        reg_wr = 0; reg_addr = 0; reg_wdata = 0; cur_time = 0; cur_date = 0;
        step(); step(); rst_n = 1'b1; #1;

        // R1 reset state
        rd(3'd0, v); chk("R1 time alarm", v, 0);
        rd(3'd1, v); chk("R1 date alarm", v, 0);
        rd(3'd2, v); chk("R1 status", v, 0);
        chk("R1 mask", {27'b0, irq_mask}, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 / R3 bit keeping
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk("R2 time readback", v, 32'h00BF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); chk("R3 date readback", v, 32'hBF9F_0000);

        // R4 / R5 sweep over enables and differing fields
        for (int en = 0; en < 32; en++) begin
            for (int df = 0; df < 32; df++) begin
                logic exp_hit;
                program_alarm(en[4:0]);
                set_cur(5'h1F); tick();
                wr(3'd3, 32'h1F);
                set_cur(df[4:0]); tick();
                exp_hit = (en != 0) && ((en & df) == 0);
                if (en == 0) chk("R5 no field enabled", {31'b0, alarm_flag}, 0);
                else         chk("R4 match sweep", {31'b0, alarm_flag}, {31'b0, exp_hit});
            end
        end

        // R6 one shot while the match holds, then re-arm
        program_alarm(5'h1F);
        set_cur(5'h1F); tick(); wr(3'd3, 32'h1F);
        set_cur(5'h00); tick();
        chk("R6 first match", {31'b0, alarm_flag}, 1);
        wr(3'd3, 32'h02); tick();
        chk("R6 no refire", {31'b0, alarm_flag}, 0);
        set_cur(5'h00); step();
        chk("R6 no set without tick", {31'b0, alarm_flag}, 0);
        set_cur(5'h04); tick(); set_cur(5'h00); tick();
        chk("R6 rearmed", {31'b0, alarm_flag}, 1);

        // R7 each source sets its own bit
        program_alarm(5'h00);
        for (int i = 0; i < 5; i++) begin
            if (i == 1) continue;
            wr(3'd3, 32'h1F);
            ev_upd_ack = (i == 0); sec_tick = (i == 2); ev_time = (i == 3); ev_date = (i == 4);
            step();
            ev_upd_ack = 0; sec_tick = 0; ev_time = 0; ev_date = 0;
            rd(3'd2, v); chk("R7 source bit", v, 32'h1 << i);
        end

        // R8 clear sweep from 0x1D
        for (int c = 0; c < 32; c++) begin
            ev_upd_ack = 1; sec_tick = 1; ev_time = 1; ev_date = 1; step();
            ev_upd_ack = 0; sec_tick = 0; ev_time = 0; ev_date = 0;
            wr(3'd3, c);
            rd(3'd2, v); chk("R8 clear pattern", v, 32'h1D & ~c);
            wr(3'd3, 32'h1F);
        end

        // R9 set beats clear
        ev_time = 1'b1; wr(3'd3, 32'h08); ev_time = 1'b0;
        rd(3'd2, v); chk("R9 set wins", v, 32'h08);
        wr(3'd3, 32'h1F);

        // R10 mask set/clear model sweep
        model = 0;
        for (int s = 0; s < 32; s++) begin
            logic [4:0] cl;
            cl = 5'((s * 7) & 31);
            wr(3'd4, s); model |= s[4:0];
            chk("R10 mask port after set", {27'b0, irq_mask}, {27'b0, model});
            wr(3'd5, {27'b0, cl}); model &= ~cl;
            rd(3'd6, v); chk("R10 mask read after clear", v, {27'b0, model});
        end

        // R11 interrupt level
        for (int m = 0; m < 32; m++) begin
            wr(3'd5, 32'h1F); wr(3'd4, m);
            chk("R11 irq with empty status", {31'b0, irq}, 0);
            ev_upd_ack = 1; sec_tick = 1; ev_time = 1; ev_date = 1; step();
            ev_upd_ack = 0; sec_tick = 0; ev_time = 0; ev_date = 0;
            chk("R11 irq level", {31'b0, irq}, {31'b0, |(5'h1D & m[4:0])});
            wr(3'd3, 32'h1F);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule